// File: doc/BRIEF.md
# ROM-Window Debug Mailbox

This block gives a target processor a two-way byte channel to a host while the only path between them is a read-only program-memory bus. The target bus carries no write strobe, so every target action is a read. Two 256-address pages of the emulated memory space are claimed by the block. A read anywhere in the transmit page sends the low eight address bits of that read to the host as one byte. The receive page has two live offsets. One is a status word that tells the target whether a host byte is waiting. The other is a data word that returns that byte and consumes it.

All target bus inputs come from another clock domain. Each of them passes through two flip-flops before use. A target read cycle is one low period of output-enable while chip-select is low. Each such period triggers at most one action. While a read falls in either page, the block raises `bus_drive`, and the surrounding memory emulation uses the block's data word instead of its own.

The host side is two byte streams with valid/ready handshakes. The outgoing stream (`tx_*`) cannot be stalled, because a memory read cannot be made to wait. `tx_valid` is a single-cycle pulse and is never held. If `tx_ready` is low in that cycle, the byte is discarded and a sticky overflow flag is set. On the incoming stream (`rx_*`), the block asserts `rx_ready` for exactly one cycle per data-offset read, and only while `rx_valid` is high. A byte moves in every cycle where both are high.

Top module: `romwin_mailbox`

## Requirements
- R1: A read cycle whose address page (bits above bit 7) equals `TX_PAGE` produces exactly one `tx_valid` pulse, and `tx_data` equals address bits [7:0] of that read.
- R2: A read cycle with output-enable held low for many clocks produces no second `tx_valid` or `rx_ready` pulse; a new action needs a new falling edge of the qualified strobe.
- R3: If `tx_ready` is low during the `tx_valid` pulse, the byte is dropped and an overflow flag is set. The flag stays set until reset and reads as bit 1 of the status word.
- R4: A read at page `RX_PAGE`, offset `STAT_OFS` returns bit 0 = `rx_valid` and bit 1 = overflow, both taken when the read action occurs; all other data bits are zero.
- R5: A read at page `RX_PAGE`, offset `DATA_OFS` with `rx_valid` high returns `rx_data` on bits [7:0] (upper bits zero) and pulses `rx_ready` for one cycle. With `rx_valid` low, it returns zero and leaves `rx_ready` low.
- R6: A read of any other receive-page offset returns zero and does not pop. A transmit-page read also presents zero on the data word.
- R7: Reads outside both pages, and output-enable strobes while chip-select is high, leave `bus_drive`, `tx_valid` and `rx_ready` low.
- R8: The action pulse (`tx_valid` or `rx_ready`) occupies the cycle after the second rising clock edge following the strobe's start. `bus_drive` is high from the third edge after the strobe starts until the third edge after it ends.
- R9: After reset, `tx_valid`, `rx_ready` and `bus_drive` are low, `bus_data` is zero and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Target word address (asynchronous) |
| bus_cs_n | input | 1 | Target chip-select, active low (asynchronous) |
| bus_oe_n | input | 1 | Target output-enable, active low (asynchronous) |
| bus_data | output | DATA_W | Data word for the target while `bus_drive` is high, zero otherwise |
| bus_drive | output | 1 | High while the block owns the read data |
| tx_data | output | 8 | Byte to host |
| tx_valid | output | 1 | Single-cycle byte pulse to host |
| tx_ready | input | 1 | Host can accept a byte |
| rx_data | input | 8 | Byte from host |
| rx_valid | input | 1 | Host byte waiting |
| rx_ready | output | 1 | Consume the waiting host byte |

## Verification
The bench builds the block with a 12-bit address, transmit page 0x5, receive page 0xA, and status and data offsets 0x10 and 0x11. Because the live offsets are not at zero, a read of offset 0x00 in the receive page must come back as an idle location and must not be taken as status. The 16-page space lets the bench read the pages next to both windows cheaply. A behavioural model with a byte queue follows every clock of each read and predicts the pulse cycle, the drive window, the data word and the overflow flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_TX,
    WIN_RX_STAT,
    WIN_RX_DATA,
    WIN_RX_IDLE
  } win_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter logic [ADDR_W-9:0] TX_PAGE  = '1 - 1'b1,
  parameter logic [ADDR_W-9:0] RX_PAGE  = '1,
  parameter logic [7:0]        STAT_OFS = 8'h00,
  parameter logic [7:0]        DATA_OFS = 8'h01
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win
);
  localparam int PAGE_LSB = 8;

  logic [ADDR_W-PAGE_LSB-1:0] page;
  logic [7:0]                 ofs;

  assign page = addr[ADDR_W-1:PAGE_LSB];
  assign ofs  = addr[PAGE_LSB-1:0];

  always_comb begin
    win = WIN_NONE;
    if (page == TX_PAGE) begin
      win = WIN_TX;
    end else if (page == RX_PAGE) begin
      if (ofs == STAT_OFS)      win = WIN_RX_STAT;
      else if (ofs == DATA_OFS) win = WIN_RX_DATA;
      else                      win = WIN_RX_IDLE;
    end
  end
endmodule

// File: rtl/mbx_tx.sv
module mbx_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] byte_in,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       overflow
);
  assign tx_valid = fire;
  assign tx_data  = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (fire && !tx_ready) overflow <= 1'b1;
  end

  assert_tx_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> overflow);
endmodule

// File: rtl/romwin_mailbox.sv
module romwin_mailbox
  import mbx_pkg::*;
#(
  parameter int                ADDR_W   = 18,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-9:0] TX_PAGE  = '1 - 1'b1,
  parameter logic [ADDR_W-9:0] RX_PAGE  = '1,
  parameter logic [7:0]        STAT_OFS = 8'h00,
  parameter logic [7:0]        DATA_OFS = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready
);
  localparam int SYN_W = ADDR_W + 2;
  localparam logic [SYN_W-1:0] SYN_RST = {2'b11, {ADDR_W{1'b0}}};

  logic [SYN_W-1:0]  syn;
  logic [ADDR_W-1:0] addr_s;
  logic              strobe, strobe_q, start;
  win_e              win;
  logic              overflow;
  logic [DATA_W-1:0] rd_word, data_q;
  logic              drive_q;

  mbx_sync #(.W(SYN_W), .RST_VAL(SYN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_cs_n, bus_oe_n, bus_addr}),
    .q     (syn)
  );

  assign addr_s = syn[ADDR_W-1:0];
  assign strobe = !syn[ADDR_W+1] && !syn[ADDR_W];
  assign start  = strobe && !strobe_q;

  mbx_decode #(
    .ADDR_W(ADDR_W), .TX_PAGE(TX_PAGE), .RX_PAGE(RX_PAGE),
    .STAT_OFS(STAT_OFS), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .addr (addr_s),
    .win  (win)
  );

  mbx_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (start && (win == WIN_TX)),
    .byte_in  (addr_s[7:0]),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .overflow (overflow)
  );

  assign rx_ready = start && (win == WIN_RX_DATA) && rx_valid;

  always_comb begin
    rd_word = '0;
    case (win)
      WIN_RX_STAT: rd_word[1:0] = {overflow, rx_valid};
      WIN_RX_DATA: if (rx_valid) rd_word[7:0] = rx_data;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      drive_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe;
      drive_q  <= strobe && (win != WIN_NONE);
      if (start) data_q <= rd_word;
    end
  end

  assign bus_drive = drive_q;
  assign bus_data  = drive_q ? data_q : '0;

  assert_pop_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_valid);
  assert_pop_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);
  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> (bus_data == '0));
  assert_drive_after_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || rx_ready) |=> bus_drive);
endmodule

// File: tb/romwin_mailbox_bench.sv
module romwin_mailbox_bench;
  localparam int AW = 12;
  localparam logic [3:0] TXP = 4'h5;
  localparam logic [3:0] RXP = 4'hA;
  localparam logic [7:0] SO  = 8'h10;
  localparam logic [7:0] DO  = 8'h11;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [AW-1:0] addr;
  logic cs_n, oe_n;
  logic [15:0] bdata;
  logic bdrv;
  logic [7:0] txd, rxd;
  logic txv, txr, rxv, rxr;

  int n_run = 0;
  int n_fail = 0;
  bit ovf_m;
  bit finished = 0;
  logic [7:0] rq[$];

  romwin_mailbox #(
    .ADDR_W(AW), .DATA_W(16), .TX_PAGE(TXP), .RX_PAGE(RXP),
    .STAT_OFS(SO), .DATA_OFS(DO)
  ) u_romwin_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_cs_n(cs_n), .bus_oe_n(oe_n),
    .bus_data(bdata), .bus_drive(bdrv), .tx_data(txd), .tx_valid(txv),
    .tx_ready(txr), .rx_data(rxd), .rx_valid(rxv), .rx_ready(rxr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rx_refresh();
    rxv = (rq.size() > 0);
    rxd = (rq.size() > 0) ? rq[0] : 8'h00;
  endtask

  task automatic expect_cyc(string req, bit etv, bit err, bit edrv, logic [15:0] ed);
    chk(req, "tx_valid", txv, etv);
    chk(req, "rx_ready", rxr, err);
    chk(req, "bus_drive", bdrv, edrv);
    chk(req, "bus_data", bdata, ed);
  endtask

  // One target read: strobe applied at a falling clock edge, held 'hold' cycles.
  task automatic bus_read(logic [AW-1:0] a, bit sel, int hold, string req);
    bit in_tx, in_win, in_st, in_dt, avail, popn;
    logic [15:0] ed;
    @(negedge clk);
    addr = a; cs_n = !sel; oe_n = 1'b0;
    in_tx  = sel && (a[AW-1:8] == TXP);
    in_win = sel && ((a[AW-1:8] == TXP) || (a[AW-1:8] == RXP));
    in_st  = sel && (a == {RXP, SO});
    in_dt  = sel && (a == {RXP, DO});
    @(negedge clk);
    expect_cyc({req, "/R8 early"}, 1'b0, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    avail = (rq.size() > 0);
    ed = 16'h0;
    if (in_st) ed = {14'b0, ovf_m, avail};
    if (in_dt && avail) ed = {8'h00, rq[0]};
    popn = in_dt && avail;
    chk({req, "/R8"}, "tx_valid", txv, in_tx);
    chk({req, "/R8"}, "rx_ready", rxr, popn);
    chk({req, "/R8"}, "bus_drive", bdrv, 1'b0);
    if (in_tx) begin
      chk({req, "/R1"}, "tx_data", txd, a[7:0]);
      if (!txr) ovf_m = 1'b1;
    end
    @(posedge clk);
    #1;
    if (popn) begin
      void'(rq.pop_front());
      rx_refresh();
    end
    for (int k = 3; k <= hold; k++) begin
      @(negedge clk);
      expect_cyc({req, "/R2"}, 1'b0, 1'b0, in_win, in_win ? ed : 16'h0);
    end
    @(negedge clk);
    cs_n = 1'b1; oe_n = 1'b1;
    for (int k = 1; k <= 2; k++) begin
      @(negedge clk);
      expect_cyc({req, "/R8 tail"}, 1'b0, 1'b0, in_win, in_win ? ed : 16'h0);
    end
    @(negedge clk);
    expect_cyc({req, "/R8 end"}, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; addr = '0; ovf_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_cyc("R9", 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int depth;
    txr = 1'b1;
    rx_refresh();
    do_reset();
    bus_read({RXP, SO}, 1'b1, 4, "R9 status");

    // R1 / R2: transmit bytes, including a long hold
    bus_read({TXP, 8'h00}, 1'b1, 3, "R1 a");
    bus_read({TXP, 8'hA5}, 1'b1, 9, "R2 hold");
    bus_read({TXP, 8'hA5}, 1'b1, 3, "R2 repeat");
    bus_read({TXP, 8'hFF}, 1'b1, 4, "R1 b");

    // R4 / R5 with an empty host queue
    bus_read({RXP, SO}, 1'b1, 4, "R4 empty");
    bus_read({RXP, DO}, 1'b1, 5, "R5 empty");

    // R5: three host bytes then an empty read
    rq.push_back(8'h3C); rq.push_back(8'h00); rq.push_back(8'hE7);
    rx_refresh();
    bus_read({RXP, SO}, 1'b1, 4, "R4 waiting");
    bus_read({RXP, DO}, 1'b1, 8, "R5 pop1");
    bus_read({RXP, DO}, 1'b1, 4, "R5 pop2");
    bus_read({RXP, DO}, 1'b1, 4, "R5 pop3");
    chk("R5", "queue depth", rq.size(), 0);
    bus_read({RXP, DO}, 1'b1, 4, "R5 drained");

    // R6: idle receive offsets, no pop
    rq.push_back(8'h99);
    rx_refresh();
    bus_read({RXP, 8'h00}, 1'b1, 4, "R6 ofs00");
    bus_read({RXP, 8'h12}, 1'b1, 4, "R6 ofs12");
    bus_read({RXP, 8'hFF}, 1'b1, 4, "R6 ofsFF");
    chk("R6", "queue depth", rq.size(), 1);

    // R7: neighbouring pages and deselected strobes
    depth = rq.size();
    bus_read({4'h4, 8'h10}, 1'b1, 4, "R7 p4");
    bus_read({4'h6, 8'h11}, 1'b1, 4, "R7 p6");
    bus_read({4'h9, DO}, 1'b1, 4, "R7 p9");
    bus_read({4'hB, DO}, 1'b1, 4, "R7 pB");
    bus_read({TXP, 8'h42}, 1'b0, 4, "R7 cs_tx");
    bus_read({RXP, DO}, 1'b0, 4, "R7 cs_rx");
    chk("R7", "queue depth", rq.size(), depth);

    // R3: dropped byte sets a sticky flag
    bus_read({RXP, SO}, 1'b1, 4, "R3 before");
    txr = 1'b0;
    bus_read({TXP, 8'h5A}, 1'b1, 4, "R3 drop");
    txr = 1'b1;
    bus_read({RXP, SO}, 1'b1, 4, "R3 flag");
    bus_read({TXP, 8'h01}, 1'b1, 4, "R3 after");
    bus_read({RXP, DO}, 1'b1, 4, "R3 pop");
    bus_read({RXP, SO}, 1'b1, 4, "R3 sticky");

    // R9: reset clears the flag
    do_reset();
    rq.delete();
    rx_refresh();
    bus_read({RXP, SO}, 1'b1, 4, "R9 cleared");

    finished = 1;
    summary();
    $finish;
  end
endmodule